// File: doc/BRIEF.md
# Fixed-Format RISC Instruction Decoder

This block turns one 32-bit instruction word into the control bundle of a single-cycle datapath. It is purely combinational. It splits the word into its register, immediate and jump formats and presents every raw field. It also produces the extended immediate, the resolved destination register number, and the full set of steering signals: register write, destination choice, ALU operation, ALU operand sources, memory access and size, branch, jump, jump-through-register and link.

Opcode 0 selects the register-register group, and inside that group the low six bits pick the operation. Every other opcode picks its operation directly. Logical operations with an immediate zero-extend it. Arithmetic, compare, memory and branch immediates are sign-extended. The upper-immediate load places the constant in the top half. A word that does not match a supported encoding raises an illegal flag, and that flag also blocks any register or memory write.

Top module: `insn_decode`

## Requirements
- R1: The raw fields always come out as follows, whatever the opcode: `rs_o`=instr[25:21], `rt_o`=instr[20:16], `rd_o`=instr[15:11], `shamt_o`=instr[10:6], `imm_o`=instr[15:0], `target_o`=instr[25:0].
- R2: When opcode (instr[31:26]) is 0, the low six bits select the operation: 32 add, 34 sub, 36 and, 37 or, 39 nor, 42 slt. The matching `alu_op_o` codes are add=0, sub=1, and=2, or=3, nor=4 and slt=7. `reg_write_o`=1, `dst_sel_o`=1 (rd) and `wr_reg_o`=rd. `alu_src_imm_o`=0 and `shamt_sel_o`=0.
- R3: When opcode is 0, low bits 0 give a left shift (`alu_op_o`=5) and low bits 2 give a right logical shift (`alu_op_o`=6). Both set `shamt_sel_o`=1 and write rd.
- R4: When opcode is 0, low bits 8 give a jump through register: `jump_reg_o`=1, `reg_write_o`=0, and no memory access.
- R5: Opcodes 8 (addi, ALU 0) and 10 (slti, ALU 7) sign-extend the 16-bit immediate into `imm_ext_o`. Opcodes 12 (andi, ALU 2) and 13 (ori, ALU 3) zero-extend it. All four set `alu_src_imm_o`=1 and `reg_write_o`=1, with `dst_sel_o`=0 (rt) and `wr_reg_o`=rt.
- R6: Opcode 15 gives `imm_ext_o`={imm,16'h0} and `alu_op_o`=8 (pass operand B). It writes rt.
- R7: Loads are opcode 32 (byte), 33 (half) and 35 (word). Each sets `mem_read_o`=1 with `mem_size_o` 0/1/2 respectively, a sign-extended offset, ALU add, an immediate operand, and a write to rt.
- R8: Stores are opcode 40 (byte), 41 (half) and 43 (word). Each sets `mem_write_o`=1 with `mem_size_o` 0/1/2 and a sign-extended offset. They set `reg_write_o`=0 and `mem_read_o`=0.
- R9: Opcode 4 (equal) and opcode 5 (not equal) set `branch_o`=1 and `alu_op_o`=1 with a register operand and a sign-extended offset. `branch_ne_o` is 1 only for opcode 5. Neither writes a register or memory.
- R10: Opcode 2 sets `jump_o`=1 with no write. Opcode 3 sets `jump_o`=1, `link_o`=1, `reg_write_o`=1, `dst_sel_o`=2 and `wr_reg_o`=31.
- R11: Any other opcode, or an unlisted low-bit code under opcode 0, sets `illegal_o`=1. In that case `reg_write_o`, `mem_write_o`, `mem_read_o`, `branch_o`, `jump_o`, `jump_reg_o` and `link_o` are all 0.
- R12: When the decode does not use memory, `mem_size_o`=0. Outside of opcodes 12, 13 and 15, `imm_ext_o` is instr[15:0] sign-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word |
| rs_o | output | 5 | First source register field |
| rt_o | output | 5 | Second source / immediate destination field |
| rd_o | output | 5 | Register-group destination field |
| shamt_o | output | 5 | Shift amount field |
| imm_o | output | 16 | Raw immediate |
| target_o | output | 26 | Raw jump target |
| imm_ext_o | output | XLEN | Extended immediate |
| wr_reg_o | output | 5 | Resolved destination register number |
| dst_sel_o | output | 2 | Destination choice: 0 rt, 1 rd, 2 link |
| reg_write_o | output | 1 | Register file write enable |
| alu_op_o | output | 4 | ALU operation code |
| alu_src_imm_o | output | 1 | ALU operand B from `imm_ext_o` |
| shamt_sel_o | output | 1 | ALU shift count from `shamt_o` |
| mem_read_o | output | 1 | Data memory read |
| mem_write_o | output | 1 | Data memory write |
| mem_size_o | output | 2 | Access size: 0 byte, 1 half, 2 word |
| branch_o | output | 1 | Conditional branch |
| branch_ne_o | output | 1 | Branch taken on inequality |
| jump_o | output | 1 | Absolute jump |
| jump_reg_o | output | 1 | Jump through register |
| link_o | output | 1 | Write return address |
| illegal_o | output | 1 | Unsupported encoding |

## Verification
Every supported encoding is applied with distinct register numbers in rs, rt and rd. This makes a wrong destination choice visible in `wr_reg_o`. Immediates are chosen with bit 15 both set and clear, so each extension mode can be told apart from the others. Further patterns cover opcodes adjacent to legal ones, unlisted low-bit codes under opcode 0, and an immediate instruction whose low bits happen to match a register-group code, which shows that the two decode paths stay separate. The all-zero and all-one words test the extremes of field extraction.

// File: rtl/insn_decode_pkg.sv
package insn_decode_pkg;

  localparam int unsigned OPW  = 6;
  localparam int unsigned REGW = 5;
  localparam int unsigned IMMW = 16;
  localparam int unsigned TGTW = 26;

  typedef enum logic [3:0] {
    ALU_ADD = 4'd0, ALU_SUB = 4'd1, ALU_AND = 4'd2, ALU_OR  = 4'd3,
    ALU_NOR = 4'd4, ALU_SLL = 4'd5, ALU_SRL = 4'd6, ALU_SLT = 4'd7,
    ALU_PASSB = 4'd8
  } alu_op_e;

  typedef enum logic [1:0] {DST_RT = 2'd0, DST_RD = 2'd1, DST_LINK = 2'd2} dst_sel_e;
  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2} mem_size_e;
  typedef enum logic [1:0] {IMM_SIGN = 2'd0, IMM_ZERO = 2'd1, IMM_UPPER = 2'd2} imm_mode_e;

  localparam logic [OPW-1:0] OP_REG  = 6'd0,  OP_J    = 6'd2,  OP_JAL  = 6'd3;
  localparam logic [OPW-1:0] OP_BEQ  = 6'd4,  OP_BNE  = 6'd5,  OP_ADDI = 6'd8;
  localparam logic [OPW-1:0] OP_SLTI = 6'd10, OP_ANDI = 6'd12, OP_ORI  = 6'd13;
  localparam logic [OPW-1:0] OP_LUI  = 6'd15, OP_LB   = 6'd32, OP_LH   = 6'd33;
  localparam logic [OPW-1:0] OP_LW   = 6'd35, OP_SB   = 6'd40, OP_SH   = 6'd41;
  localparam logic [OPW-1:0] OP_SW   = 6'd43;

  localparam logic [5:0] FN_SLL = 6'd0,  FN_SRL = 6'd2,  FN_JR  = 6'd8;
  localparam logic [5:0] FN_ADD = 6'd32, FN_SUB = 6'd34, FN_AND = 6'd36;
  localparam logic [5:0] FN_OR  = 6'd37, FN_NOR = 6'd39, FN_SLT = 6'd42;

  typedef struct packed {
    logic      reg_write;
    dst_sel_e  dst_sel;
    alu_op_e   alu_op;
    logic      alu_src_imm;
    logic      shamt_sel;
    logic      mem_read;
    logic      mem_write;
    mem_size_e mem_size;
    logic      branch;
    logic      branch_ne;
    logic      jump;
    logic      jump_reg;
    logic      link;
    logic      illegal;
    imm_mode_e imm_mode;
  } ctrl_t;

  function automatic ctrl_t ctrl_idle();
    ctrl_t c;
    c.reg_write   = 1'b0;
    c.dst_sel     = DST_RT;
    c.alu_op      = ALU_ADD;
    c.alu_src_imm = 1'b0;
    c.shamt_sel   = 1'b0;
    c.mem_read    = 1'b0;
    c.mem_write   = 1'b0;
    c.mem_size    = SZ_BYTE;
    c.branch      = 1'b0;
    c.branch_ne   = 1'b0;
    c.jump        = 1'b0;
    c.jump_reg    = 1'b0;
    c.link        = 1'b0;
    c.illegal     = 1'b0;
    c.imm_mode    = IMM_SIGN;
    return c;
  endfunction

endpackage

// File: rtl/insn_fields.sv
module insn_fields
  import insn_decode_pkg::*;
(
  input  logic [31:0]      instr_i,
  output logic [OPW-1:0]   op_o,
  output logic [REGW-1:0]  rs_o,
  output logic [REGW-1:0]  rt_o,
  output logic [REGW-1:0]  rd_o,
  output logic [REGW-1:0]  shamt_o,
  output logic [5:0]       funct_o,
  output logic [IMMW-1:0]  imm_o,
  output logic [TGTW-1:0]  target_o
);
  assign op_o     = instr_i[31:26];
  assign rs_o     = instr_i[25:21];
  assign rt_o     = instr_i[20:16];
  assign rd_o     = instr_i[15:11];
  assign shamt_o  = instr_i[10:6];
  assign funct_o  = instr_i[5:0];
  assign imm_o    = instr_i[15:0];
  assign target_o = instr_i[25:0];
endmodule

// File: rtl/insn_rgroup.sv
module insn_rgroup
  import insn_decode_pkg::*;
(
  input  logic [5:0] funct_i,
  output ctrl_t      ctrl_o
);
  always_comb begin
    ctrl_o         = ctrl_idle();
    ctrl_o.dst_sel = DST_RD;
    unique case (funct_i)
      FN_ADD: begin ctrl_o.reg_write = 1'b1; ctrl_o.alu_op = ALU_ADD; end
      FN_SUB: begin ctrl_o.reg_write = 1'b1; ctrl_o.alu_op = ALU_SUB; end
      FN_AND: begin ctrl_o.reg_write = 1'b1; ctrl_o.alu_op = ALU_AND; end
      FN_OR:  begin ctrl_o.reg_write = 1'b1; ctrl_o.alu_op = ALU_OR;  end
      FN_NOR: begin ctrl_o.reg_write = 1'b1; ctrl_o.alu_op = ALU_NOR; end
      FN_SLT: begin ctrl_o.reg_write = 1'b1; ctrl_o.alu_op = ALU_SLT; end
      FN_SLL: begin
        ctrl_o.reg_write = 1'b1;
        ctrl_o.alu_op    = ALU_SLL;
        ctrl_o.shamt_sel = 1'b1;
      end
      FN_SRL: begin
        ctrl_o.reg_write = 1'b1;
        ctrl_o.alu_op    = ALU_SRL;
        ctrl_o.shamt_sel = 1'b1;
      end
      FN_JR:   ctrl_o.jump_reg = 1'b1;
      default: ctrl_o.illegal  = 1'b1;
    endcase
  end
endmodule

// File: rtl/insn_main.sv
module insn_main
  import insn_decode_pkg::*;
(
  input  logic [OPW-1:0] op_i,
  input  ctrl_t          rgrp_i,
  output ctrl_t          ctrl_o
);
  always_comb begin
    ctrl_o = ctrl_idle();
    unique case (op_i)
      OP_REG: ctrl_o = rgrp_i;
      OP_J:   ctrl_o.jump = 1'b1;
      OP_JAL: begin
        ctrl_o.jump      = 1'b1;
        ctrl_o.link      = 1'b1;
        ctrl_o.reg_write = 1'b1;
        ctrl_o.dst_sel   = DST_LINK;
      end
      OP_BEQ, OP_BNE: begin
        ctrl_o.branch    = 1'b1;
        ctrl_o.branch_ne = (op_i == OP_BNE);
        ctrl_o.alu_op    = ALU_SUB;
      end
      OP_ADDI, OP_SLTI, OP_ANDI, OP_ORI, OP_LUI: begin
        ctrl_o.reg_write   = 1'b1;
        ctrl_o.alu_src_imm = 1'b1;
        unique case (op_i)
          OP_SLTI: ctrl_o.alu_op = ALU_SLT;
          OP_ANDI: begin ctrl_o.alu_op = ALU_AND;   ctrl_o.imm_mode = IMM_ZERO;  end
          OP_ORI:  begin ctrl_o.alu_op = ALU_OR;    ctrl_o.imm_mode = IMM_ZERO;  end
          OP_LUI:  begin ctrl_o.alu_op = ALU_PASSB; ctrl_o.imm_mode = IMM_UPPER; end
          default: ctrl_o.alu_op = ALU_ADD;
        endcase
      end
      OP_LB, OP_LH, OP_LW: begin
        ctrl_o.reg_write   = 1'b1;
        ctrl_o.alu_src_imm = 1'b1;
        ctrl_o.mem_read    = 1'b1;
        ctrl_o.mem_size    = (op_i == OP_LB) ? SZ_BYTE :
                             (op_i == OP_LH) ? SZ_HALF : SZ_WORD;
      end
      OP_SB, OP_SH, OP_SW: begin
        ctrl_o.alu_src_imm = 1'b1;
        ctrl_o.mem_write   = 1'b1;
        ctrl_o.mem_size    = (op_i == OP_SB) ? SZ_BYTE :
                             (op_i == OP_SH) ? SZ_HALF : SZ_WORD;
      end
      default: ctrl_o.illegal = 1'b1;
    endcase
  end
endmodule

// File: rtl/insn_immext.sv
module insn_immext
  import insn_decode_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [IMMW-1:0] imm_i,
  input  imm_mode_e       mode_i,
  output logic [XLEN-1:0] imm_ext_o
);
  localparam int unsigned PADW = XLEN - IMMW;

  logic [XLEN-1:0] sext, zext, upper;

  assign sext = {{PADW{imm_i[IMMW-1]}}, imm_i};
  assign zext = {{PADW{1'b0}}, imm_i};

  generate
    if (PADW >= IMMW) begin : g_wide
      assign upper = {imm_i, {PADW{1'b0}}} >> (PADW - IMMW);
    end else begin : g_narrow
      assign upper = zext;
    end
  endgenerate

  always_comb begin
    unique case (mode_i)
      IMM_ZERO:  imm_ext_o = zext;
      IMM_UPPER: imm_ext_o = upper;
      default:   imm_ext_o = sext;
    endcase
  end
endmodule

// File: rtl/insn_decode.sv
module insn_decode
  import insn_decode_pkg::*;
#(
  parameter int unsigned XLEN     = 32,
  parameter int unsigned LINK_REG = 31
) (
  input  logic [31:0]     instr_i,
  output logic [4:0]      rs_o,
  output logic [4:0]      rt_o,
  output logic [4:0]      rd_o,
  output logic [4:0]      shamt_o,
  output logic [15:0]     imm_o,
  output logic [25:0]     target_o,
  output logic [XLEN-1:0] imm_ext_o,
  output logic [4:0]      wr_reg_o,
  output logic [1:0]      dst_sel_o,
  output logic            reg_write_o,
  output logic [3:0]      alu_op_o,
  output logic            alu_src_imm_o,
  output logic            shamt_sel_o,
  output logic            mem_read_o,
  output logic            mem_write_o,
  output logic [1:0]      mem_size_o,
  output logic            branch_o,
  output logic            branch_ne_o,
  output logic            jump_o,
  output logic            jump_reg_o,
  output logic            link_o,
  output logic            illegal_o
);
  localparam logic [REGW-1:0] LINK_IDX = REGW'(LINK_REG);

  logic [OPW-1:0] op;
  logic [5:0]     funct;
  ctrl_t          rgrp_ctrl, ctrl;

  insn_fields u_fields (
    .instr_i  (instr_i),
    .op_o     (op),
    .rs_o     (rs_o),
    .rt_o     (rt_o),
    .rd_o     (rd_o),
    .shamt_o  (shamt_o),
    .funct_o  (funct),
    .imm_o    (imm_o),
    .target_o (target_o)
  );

  insn_rgroup u_rgroup (
    .funct_i (funct),
    .ctrl_o  (rgrp_ctrl)
  );

  insn_main u_main (
    .op_i   (op),
    .rgrp_i (rgrp_ctrl),
    .ctrl_o (ctrl)
  );

  insn_immext #(.XLEN(XLEN)) u_immext (
    .imm_i     (imm_o),
    .mode_i    (ctrl.imm_mode),
    .imm_ext_o (imm_ext_o)
  );

  always_comb begin
    unique case (ctrl.dst_sel)
      DST_RD:   wr_reg_o = rd_o;
      DST_LINK: wr_reg_o = LINK_IDX;
      default:  wr_reg_o = rt_o;
    endcase
  end

  assign dst_sel_o     = ctrl.dst_sel;
  assign reg_write_o   = ctrl.reg_write;
  assign alu_op_o      = ctrl.alu_op;
  assign alu_src_imm_o = ctrl.alu_src_imm;
  assign shamt_sel_o   = ctrl.shamt_sel;
  assign mem_read_o    = ctrl.mem_read;
  assign mem_write_o   = ctrl.mem_write;
  assign mem_size_o    = ctrl.mem_size;
  assign branch_o      = ctrl.branch;
  assign branch_ne_o   = ctrl.branch_ne;
  assign jump_o        = ctrl.jump;
  assign jump_reg_o    = ctrl.jump_reg;
  assign link_o        = ctrl.link;
  assign illegal_o     = ctrl.illegal;
endmodule

// File: rtl/insn_decode_chk.sv
module insn_decode_chk #(
  parameter int unsigned XLEN = 32
) (
  input logic [31:0]     instr_i,
  input logic [XLEN-1:0] imm_ext_o,
  input logic [4:0]      wr_reg_o,
  input logic [1:0]      dst_sel_o,
  input logic            reg_write_o,
  input logic            mem_read_o,
  input logic            mem_write_o,
  input logic            branch_o,
  input logic            jump_o,
  input logic            link_o,
  input logic            illegal_o
);
  always_comb begin
    if (!$isunknown(instr_i)) begin
      // R11
      illegal_quiet_chk: assert (!illegal_o || !(reg_write_o || mem_write_o || mem_read_o || jump_o || branch_o))
        else $error("illegal encoding still drives a side effect");
      // R8
      mem_excl_chk: assert (!(mem_read_o && mem_write_o))
        else $error("read and write together");
      // R10
      link_dest_chk: assert (!link_o || (reg_write_o && wr_reg_o == 5'd31))
        else $error("link without write to register 31");
      // R2
      rd_dest_chk: assert (dst_sel_o != 2'd1 || wr_reg_o == instr_i[15:11])
        else $error("rd selected but another register written");
      // R5
      zext_chk: assert (!((instr_i[31:26] == 6'd12 || instr_i[31:26] == 6'd13)) || imm_ext_o[XLEN-1:16] == '0)
        else $error("logical immediate not zero-extended");
      // R9
      branch_quiet_chk: assert (!branch_o || !(reg_write_o || mem_write_o))
        else $error("branch writes state");
    end
  end
endmodule

bind insn_decode insn_decode_chk #(.XLEN(XLEN)) u_chk (
  .instr_i     (instr_i),
  .imm_ext_o   (imm_ext_o),
  .wr_reg_o    (wr_reg_o),
  .dst_sel_o   (dst_sel_o),
  .reg_write_o (reg_write_o),
  .mem_read_o  (mem_read_o),
  .mem_write_o (mem_write_o),
  .branch_o    (branch_o),
  .jump_o      (jump_o),
  .link_o      (link_o),
  .illegal_o   (illegal_o)
);

// File: tb/sim_insn_decode.sv
`timescale 1ns/1ps
module sim_insn_decode;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [31:0] instr;
  logic [4:0]  rs, rt, rd, shamt, wr_reg;
  logic [15:0] imm;
  logic [25:0] target;
  logic [31:0] imm_ext;
  logic [1:0]  dst_sel, mem_size;
  logic [3:0]  alu_op;
  logic reg_write, alu_src_imm, shamt_sel, mem_read, mem_write;
  logic branch, branch_ne, jump, jump_reg, link, illegal;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  insn_decode u0 (
    .instr_i(instr), .rs_o(rs), .rt_o(rt), .rd_o(rd), .shamt_o(shamt),
    .imm_o(imm), .target_o(target), .imm_ext_o(imm_ext), .wr_reg_o(wr_reg),
    .dst_sel_o(dst_sel), .reg_write_o(reg_write), .alu_op_o(alu_op),
    .alu_src_imm_o(alu_src_imm), .shamt_sel_o(shamt_sel), .mem_read_o(mem_read),
    .mem_write_o(mem_write), .mem_size_o(mem_size), .branch_o(branch),
    .branch_ne_o(branch_ne), .jump_o(jump), .jump_reg_o(jump_reg),
    .link_o(link), .illegal_o(illegal)
  );

  function automatic logic [31:0] rf(int s, int t, int d, int sh, int fn);
    return {6'd0, 5'(s), 5'(t), 5'(d), 5'(sh), 6'(fn)};
  endfunction
  function automatic logic [31:0] imf(int op, int s, int t, logic [15:0] k);
    return {6'(op), 5'(s), 5'(t), k};
  endfunction
  function automatic logic [31:0] jf(int op, logic [25:0] tg);
    return {6'(op), tg};
  endfunction
  // {rw, dst[2], alu[4], srci, shs, mr, mw, size[2], br, bne, j, jr, lk, il}
  function automatic logic [18:0] cw(bit rw, int ds, int alu, bit si, bit ss, bit mr, bit mw,
                                     int sz, bit br, bit bn, bit j, bit jr, bit lk, bit il);
    return {rw, 2'(ds), 4'(alu), si, ss, mr, mw, 2'(sz), br, bn, j, jr, lk, il};
  endfunction
  // entry: {instr[32], ctrl[19], imm mode[2], req[4]}
  function automatic logic [56:0] row(logic [31:0] i, logic [18:0] c, int m, int r);
    return {i, c, 2'(m), 4'(r)};
  endfunction

  localparam int NV = 29;
  localparam logic [56:0] VEC [NV] = '{
    row(rf(17,18,9,0,32),  cw(1,1,0,0,0,0,0,0,0,0,0,0,0,0), 0, 2),  // R2 add
    row(rf(17,18,9,0,34),  cw(1,1,1,0,0,0,0,0,0,0,0,0,0,0), 0, 2),  // R2 sub
    row(rf(17,18,9,0,36),  cw(1,1,2,0,0,0,0,0,0,0,0,0,0,0), 0, 2),  // R2 and
    row(rf(17,18,9,0,37),  cw(1,1,3,0,0,0,0,0,0,0,0,0,0,0), 0, 2),  // R2 or
    row(rf(17,18,9,0,39),  cw(1,1,4,0,0,0,0,0,0,0,0,0,0,0), 0, 2),  // R2 nor
    row(rf(17,18,9,0,42),  cw(1,1,7,0,0,0,0,0,0,0,0,0,0,0), 0, 2),  // R2 slt
    row(rf(0,18,17,10,0),  cw(1,1,5,0,1,0,0,0,0,0,0,0,0,0), 0, 3),  // R3 sll
    row(rf(0,19,17,31,2),  cw(1,1,6,0,1,0,0,0,0,0,0,0,0,0), 0, 3),  // R3 srl
    row(rf(31,0,0,0,8),    cw(0,1,0,0,0,0,0,0,0,0,0,1,0,0), 0, 4),  // R4 jr
    row(imf(8,17,16,16'hFFF4),  cw(1,0,0,1,0,0,0,0,0,0,0,0,0,0), 0, 5), // R5 addi
    row(imf(10,17,16,16'h8000), cw(1,0,7,1,0,0,0,0,0,0,0,0,0,0), 0, 5), // R5 slti
    row(imf(12,17,16,16'h8001), cw(1,0,2,1,0,0,0,0,0,0,0,0,0,0), 1, 5), // R5 andi
    row(imf(13,17,16,16'hAAAA), cw(1,0,3,1,0,0,0,0,0,0,0,0,0,0), 1, 5), // R5 ori
    row(imf(8,3,4,16'h0022),    cw(1,0,0,1,0,0,0,0,0,0,0,0,0,0), 0, 5), // R5 addi, low bits look like sub
    row(imf(15,0,8,16'hAAAA),   cw(1,0,8,1,0,0,0,0,0,0,0,0,0,0), 2, 6), // R6 lui
    row(imf(35,19,8,16'h0020),  cw(1,0,0,1,0,1,0,2,0,0,0,0,0,0), 0, 7), // R7 lw
    row(imf(33,19,8,16'hFFFC),  cw(1,0,0,1,0,1,0,1,0,0,0,0,0,0), 0, 7), // R7 lh
    row(imf(32,19,8,16'h7FFF),  cw(1,0,0,1,0,1,0,0,0,0,0,0,0,0), 0, 7), // R7 lb
    row(imf(43,19,8,16'h0030),  cw(0,0,0,1,0,0,1,2,0,0,0,0,0,0), 0, 8), // R8 sw
    row(imf(41,19,8,16'hFF00),  cw(0,0,0,1,0,0,1,1,0,0,0,0,0,0), 0, 8), // R8 sh
    row(imf(40,19,8,16'h0001),  cw(0,0,0,1,0,0,1,0,0,0,0,0,0,0), 0, 8), // R8 sb
    row(imf(4,17,18,16'd25),    cw(0,0,1,0,0,0,0,0,1,0,0,0,0,0), 0, 9), // R9 beq
    row(imf(5,17,18,16'hFFFE),  cw(0,0,1,0,0,0,0,0,1,1,0,0,0,0), 0, 9), // R9 bne
    row(jf(2,26'd2500),         cw(0,0,0,0,0,0,0,0,0,0,1,0,0,0), 0, 10), // R10 j
    row(jf(3,26'h3FFFFFF),      cw(1,2,0,0,0,0,0,0,0,0,1,0,1,0), 0, 10), // R10 jal
    row(imf(63,1,2,16'h1234),   cw(0,0,0,0,0,0,0,0,0,0,0,0,0,1), 0, 11), // R11 op 63
    row(rf(5,6,7,0,1),          cw(0,1,0,0,0,0,0,0,0,0,0,0,0,1), 0, 11), // R11 funct 1
    row(imf(6,5,6,16'h8000),    cw(0,0,0,0,0,0,0,0,0,0,0,0,0,1), 0, 11), // R11 op 6
    row(rf(9,10,11,0,43),       cw(0,1,0,0,0,0,0,0,0,0,0,0,0,1), 0, 11)  // R11 funct 43
  };

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s instr=%h act=%h exp=%h", req, instr, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_imm(logic [15:0] k, int m);
    if (m == 1) return {16'h0, k};
    if (m == 2) return {k, 16'h0};
    return {{16{k[15]}}, k};
  endfunction

  function automatic logic [4:0] exp_wr(logic [31:0] i, logic [1:0] ds);
    if (ds == 2'd1) return i[15:11];
    if (ds == 2'd2) return 5'd31;
    return i[20:16];
  endfunction

  task automatic apply(logic [31:0] w);
    @(posedge clk);
    instr = w;
    @(negedge clk);
  endtask

  task automatic fields_chk(string req);
    chk(req, {rs, rt, rd, shamt}, {instr[25:21], instr[20:16], instr[15:11], instr[10:6]});
    chk(req, {imm, target}, {instr[15:0], instr[25:0]});
  endtask

  function automatic logic [18:0] ctl_now();
    return {reg_write, dst_sel, alu_op, alu_src_imm, shamt_sel, mem_read, mem_write,
            mem_size, branch, branch_ne, jump, jump_reg, link, illegal};
  endfunction

  initial begin
    instr = '0;
    // R12 baseline: all-zero word is a shift of r0 by 0 into r0
    apply(32'h0);
    chk("R3", 64'(ctl_now()), 64'(cw(1,1,5,0,1,0,0,0,0,0,0,0,0,0)));
    chk("R12", 64'({imm_ext, wr_reg}), 64'({32'h0, 5'd0}));
    fields_chk("R1");

    for (int i = 0; i < NV; i++) begin
      logic [31:0] w;
      logic [18:0] c;
      w = VEC[i][56:25];
      c = VEC[i][24:6];
      apply(w);
      chk($sformatf("R%0d", VEC[i][3:0]), 64'(ctl_now()), 64'(c));
      // R12 extension and resolved destination
      chk($sformatf("R%0d/R12 imm", VEC[i][3:0]), 64'(imm_ext), 64'(exp_imm(w[15:0], int'(VEC[i][5:4]))));
      chk($sformatf("R%0d wr_reg", VEC[i][3:0]), 64'(wr_reg), 64'(exp_wr(w, c[17:16])));
      fields_chk("R1");
    end

    // R1 R11: all-ones word
    apply(32'hFFFF_FFFF);
    fields_chk("R1");
    chk("R11", 64'({illegal, reg_write, mem_write, mem_read, jump, link}), 64'(6'b100000));

    // R10 jal with a zero target still links to 31
    apply(jf(3, 26'd0));
    chk("R10", 64'({link, reg_write, wr_reg}), 64'({1'b1, 1'b1, 5'd31}));

    // R7 load/store pair differ only in direction
    apply(imf(35, 1, 2, 16'h8000));
    chk("R7", 64'({mem_read, mem_write, imm_ext}), 64'({1'b1, 1'b0, 32'hFFFF_8000}));
    apply(imf(43, 1, 2, 16'h8000));
    chk("R8", 64'({mem_read, mem_write, reg_write, imm_ext}), 64'({1'b0, 1'b1, 1'b0, 32'hFFFF_8000}));

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule